// File: doc/BRIEF.md
# Fixed-Point Range-Scaling Wrapper for Reciprocal and Root Functions

This block lets a function core that only works on arguments in [1,2) serve any fixed-point input format. A front stage finds the leading one of the input magnitude, shifts it into [1,2) and derives the binary exponent s, so that the input equals 2^s times the normalized mantissa. A table core then evaluates the reciprocal, square root or reciprocal square root of the mantissa. A back stage scales the core result by 2^(-s), 2^(s/2) or 2^(-s/2), brings it to a leading-one alignment, rounds it, saturates it and restores the sign.

For the reciprocal the input is a signed two's-complement number, and its magnitude is what gets normalized. For the two root functions the input is read as unsigned. When s is odd, a root function gets a doubled mantissa and the exponent s-1, so that the halved exponent stays an integer. The datapath is a fixed pipeline. A new operation may enter every cycle, and each result leaves with a valid strobe after LATENCY cycles (LATENCY must be 3 or more).

Top module: `fx_range_scaler`

## Requirements
- R1: Input value is data_i·2^-IN_F (signed for the reciprocal, unsigned for both roots); output value is data_o·2^-OUT_F in two's complement; func_i code 0 selects reciprocal, 1 square root, 2 reciprocal square root, and 3 behaves as square root.
- R2: The core sees only the MANT_A bits that follow the leading one (lower bits are truncated) and returns its function of that mantissa rounded to nearest with CORE_F fraction bits.
- R3: The exponent s is the bit position of the leading one minus IN_F; the reciprocal result is scaled by 2^-s, so inputs that are powers of two give exact reciprocals (1.0 gives 64, 2.0 gives 32 with defaults).
- R4: A negative reciprocal input is replaced by its magnitude, and the final result is negated; root functions never negate (input 0x800 is +8.0 for them).
- R5: For the roots an odd s doubles the mantissa and uses s-1; the square root is scaled by 2^(s/2), the reciprocal square root by 2^(-s/2).
- R6: Rounding is to nearest with ties rounded up on the magnitude, and the sign is applied afterwards (sqrt(2.0) gives 91 from 90.5; -1/3 gives -21).
- R7: A core result below 1.0 is shifted left by one place and its exponent is lowered by one before the final shift, so no precision is lost (1/3 gives 21).
- R8: A magnitude above 2^(OUT_W-1)-1 saturates to +2047, or to -2047 for a negative reciprocal (defaults).
- R9: A zero input gives +2047 with exc_o=1 for the reciprocal and the reciprocal square root; the square root of zero gives 0 with exc_o=0; exc_o is 0 for every nonzero input.
- R10: valid_o rises exactly LATENCY cycles after valid_i. Back-to-back inputs come out on consecutive cycles. During reset valid_o, data_o and exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operand valid |
| func_i | input | 2 | Function select |
| data_i | input | IN_W | Fixed-point operand |
| valid_o | output | 1 | Result valid |
| data_o | output | OUT_W | Scaled, rounded, signed result |
| exc_o | output | 1 | Zero-input exception for the inverting functions |

## Verification
The hardest case to reach is the path where the core value is below one, so the alignment shift has to act together with the odd-exponent fold of a root function and with a tie in the final rounding. The stimulus reaches it with chosen operands: 2.0 and 8.0 give odd exponents, and sqrt(2.0) lands on an exact tie. Saturation and sign handling are reached through tiny positive and negative reciprocal operands and the most negative code. Back-to-back issue checks that results leave on consecutive cycles.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  localparam logic [1:0] FN_RECIP = 2'd0;
  localparam logic [1:0] FN_SQRT  = 2'd1;
  localparam logic [1:0] FN_RSQRT = 2'd2;
  localparam logic [1:0] FN_ALT   = 2'd3;  // decoded as square root

  function automatic logic fn_is_root(logic [1:0] f);
    return f != FN_RECIP;
  endfunction

  function automatic logic fn_is_inv(logic [1:0] f);
    return (f == FN_RECIP) || (f == FN_RSQRT);
  endfunction
endpackage

// File: rtl/fx_prescale.sv
module fx_prescale
  import fxs_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int IN_F   = 8,
  parameter int MANT_A = 6,
  parameter int EXP_W  = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              func_i,
  input  logic [IN_W-1:0]         data_i,
  output logic                    valid_o,
  output logic [1:0]              func_o,
  output logic                    neg_o,
  output logic                    zero_o,
  output logic                    odd_o,
  output logic [MANT_A-1:0]       frac_o,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam int LZW = $clog2(IN_W);

  logic                    neg, zero, odd;
  logic [IN_W-1:0]         mag;
  logic [LZW-1:0]          lead, lz;
  logic [MANT_A-1:0]       frac;
  logic signed [EXP_W-1:0] s_raw, s_adj;

  always_comb begin
    neg  = (func_i == FN_RECIP) && data_i[IN_W-1];
    mag  = neg ? (~data_i + 1'b1) : data_i;
    zero = (mag == '0);
    lead = '0;
    for (int i = 0; i < IN_W; i++)
      if (mag[i]) lead = LZW'(i);
    lz    = LZW'(IN_W - 1) - lead;
    // mantissa bits just below the leading one
    frac  = MANT_A'((mag << lz) >> (IN_W - 1 - MANT_A));
    s_raw = EXP_W'(IN_W - 1 - IN_F - int'(lz));
    odd   = fn_is_root(func_i) && s_raw[0];
    s_adj = odd ? (s_raw - EXP_W'(1)) : s_raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      func_o  <= FN_RECIP;
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      odd_o   <= 1'b0;
      frac_o  <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      func_o  <= func_i;
      neg_o   <= neg;
      zero_o  <= zero;
      odd_o   <= odd;
      frac_o  <= frac;
      exp_o   <= s_adj;
    end
  end

  AST_NORM_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero) |-> (((mag << lz) >> (IN_W - 1)) == IN_W'(1))); // R3
  AST_ABS_RECIP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && func_o != FN_RECIP) |-> !neg_o); // R4
  AST_EVEN_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fn_is_root(func_o)) |-> !exp_o[0]); // R5
endmodule

// File: rtl/fx_table_core.sv
module fx_table_core
  import fxs_pkg::*;
#(
  parameter int MANT_A = 6,
  parameter int CORE_F = 10,
  parameter int EXP_W  = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              func_i,
  input  logic                    neg_i,
  input  logic                    zero_i,
  input  logic                    odd_i,
  input  logic [MANT_A-1:0]       frac_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                    valid_o,
  output logic [1:0]              func_o,
  output logic                    neg_o,
  output logic                    zero_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [CORE_F:0]         y_o
);
  localparam int RN = 2 ** MANT_A;
  localparam int RT = 2 * RN;
  localparam logic [CORE_F:0] ONE  = (CORE_F+1)'(1) << CORE_F;
  localparam logic [CORE_F:0] HALF = (CORE_F+1)'(1) << (CORE_F - 1);

  function automatic longint isqrt(longint n);
    longint r = 0;
    for (int b = 30; b >= 0; b--) begin
      longint c = r | (longint'(1) << b);
      if (c * c <= n) r = c;
    end
    return r;
  endfunction

  function automatic longint recip_val(int i);
    longint m = longint'(RN + i);
    return ((longint'(1) << (CORE_F + MANT_A + 1)) / m + 1) / 2;
  endfunction

  function automatic longint sqrt_val(int i);
    longint m = longint'(RN + (i % RN)) << (i / RN);
    return (isqrt((m << (2 * CORE_F - MANT_A)) * 4) + 1) / 2;
  endfunction

  function automatic longint rsqrt_val(int i);
    longint m = longint'(RN + (i % RN)) << (i / RN);
    return (isqrt((longint'(1) << (2 * CORE_F + MANT_A + 2)) / m) + 1) / 2;
  endfunction

  logic [CORE_F:0] recip_tab [RN];
  logic [CORE_F:0] sqrt_tab  [RT];
  logic [CORE_F:0] rsqrt_tab [RT];

  for (genvar g = 0; g < RN; g++) begin : g_recip
    localparam logic [CORE_F:0] V = (CORE_F+1)'(recip_val(g));
    assign recip_tab[g] = V;
  end
  for (genvar g = 0; g < RT; g++) begin : g_root
    localparam logic [CORE_F:0] VS = (CORE_F+1)'(sqrt_val(g));
    localparam logic [CORE_F:0] VR = (CORE_F+1)'(rsqrt_val(g));
    assign sqrt_tab[g]  = VS;
    assign rsqrt_tab[g] = VR;
  end

  logic [MANT_A:0] idx;
  logic [CORE_F:0] y;

  always_comb begin
    idx = {odd_i, frac_i};
    if (!fn_is_root(func_i)) y = recip_tab[frac_i];
    else if (func_i[0])      y = sqrt_tab[idx];
    else                     y = rsqrt_tab[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      func_o  <= FN_RECIP;
      neg_o   <= 1'b0;
      zero_o  <= 1'b0;
      exp_o   <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      func_o  <= func_i;
      neg_o   <= neg_i;
      zero_o  <= zero_i;
      exp_o   <= exp_i;
      y_o     <= y;
    end
  end

  AST_CORE_INV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !zero_o && fn_is_inv(func_o)) |-> (y_o > HALF && y_o <= ONE)); // R2
  AST_CORE_ROOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !zero_o && !fn_is_inv(func_o)) |-> (y_o >= ONE)); // R2
endmodule

// File: rtl/fx_postscale.sv
module fx_postscale
  import fxs_pkg::*;
#(
  parameter int CORE_F = 10,
  parameter int OUT_W  = 12,
  parameter int OUT_F  = 6,
  parameter int EXP_W  = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              func_i,
  input  logic                    neg_i,
  input  logic                    zero_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [CORE_F:0]         y_i,
  output logic                    valid_o,
  output logic [OUT_W-1:0]        data_o,
  output logic                    exc_o
);
  localparam int WW = OUT_W + CORE_F + 2;
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic                    low, sat, exc;
  logic [CORE_F:0]         yn;
  logic signed [EXP_W-1:0] e_fn;
  logic [WW-1:0]           t;
  logic [OUT_W-1:0]        res, data;
  int                      ki, sh;

  always_comb begin
    // align: core value below one gets one extra place
    low = !y_i[CORE_F];
    yn  = low ? {y_i[CORE_F-1:0], 1'b0} : y_i;
    if (!fn_is_root(func_i)) e_fn = -exp_i;
    else if (func_i[0])      e_fn = exp_i >>> 1;
    else                     e_fn = -(exp_i >>> 1);
    ki  = int'(e_fn) - (low ? 1 : 0) + OUT_F - CORE_F;
    sh  = 0;
    sat = 1'b0;
    t   = '0;
    if (ki >= 0) begin
      if (ki > OUT_W) sat = 1'b1;
      else            t = WW'(yn) << ki;
    end else begin
      sh = -ki;
      if (sh <= CORE_F + 1)
        t = (WW'(yn) + (WW'(1) << (sh - 1))) >> sh;
    end
    if (t > WW'(MAX_POS)) sat = 1'b1;
    exc = 1'b0;
    if (zero_i) begin
      exc = fn_is_inv(func_i);
      res = exc ? MAX_POS : '0;
    end else begin
      res = sat ? MAX_POS : OUT_W'(t);
    end
    data = neg_i ? (~res + 1'b1) : res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      exc_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o  <= data;
      exc_o   <= exc;
    end
  end

  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_i) |-> yn[CORE_F]); // R7
  AST_ROOT_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fn_is_root(func_i)) |=> !data_o[OUT_W-1]); // R4
endmodule

// File: rtl/fx_range_scaler.sv
module fx_range_scaler
  import fxs_pkg::*;
#(
  parameter int IN_W    = 12,
  parameter int IN_F    = 8,
  parameter int OUT_W   = 12,
  parameter int OUT_F   = 6,
  parameter int MANT_A  = 6,
  parameter int CORE_F  = 10,
  parameter int LATENCY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       func_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             exc_o
);
  localparam int EXP_W = $clog2(IN_W + OUT_W + CORE_F + 4) + 1;
  localparam int XTRA  = LATENCY - 3;
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic                    p_valid, p_neg, p_zero, p_odd;
  logic [1:0]              p_func;
  logic [MANT_A-1:0]       p_frac;
  logic signed [EXP_W-1:0] p_exp;
  logic                    c_valid, c_neg, c_zero;
  logic [1:0]              c_func;
  logic signed [EXP_W-1:0] c_exp;
  logic [CORE_F:0]         c_y;
  logic                    s_valid, s_exc;
  logic [OUT_W-1:0]        s_data;

  fx_prescale #(.IN_W(IN_W), .IN_F(IN_F), .MANT_A(MANT_A), .EXP_W(EXP_W)) u_pre (
    .clk_i, .rst_ni, .valid_i, .func_i, .data_i,
    .valid_o(p_valid), .func_o(p_func), .neg_o(p_neg), .zero_o(p_zero),
    .odd_o(p_odd), .frac_o(p_frac), .exp_o(p_exp)
  );

  fx_table_core #(.MANT_A(MANT_A), .CORE_F(CORE_F), .EXP_W(EXP_W)) u_core (
    .clk_i, .rst_ni, .valid_i(p_valid), .func_i(p_func), .neg_i(p_neg),
    .zero_i(p_zero), .odd_i(p_odd), .frac_i(p_frac), .exp_i(p_exp),
    .valid_o(c_valid), .func_o(c_func), .neg_o(c_neg), .zero_o(c_zero),
    .exp_o(c_exp), .y_o(c_y)
  );

  fx_postscale #(.CORE_F(CORE_F), .OUT_W(OUT_W), .OUT_F(OUT_F), .EXP_W(EXP_W)) u_post (
    .clk_i, .rst_ni, .valid_i(c_valid), .func_i(c_func), .neg_i(c_neg),
    .zero_i(c_zero), .exp_i(c_exp), .y_i(c_y),
    .valid_o(s_valid), .data_o(s_data), .exc_o(s_exc)
  );

  if (XTRA > 0) begin : g_dly
    logic             dv [XTRA];
    logic [OUT_W-1:0] dd [XTRA];
    logic             de [XTRA];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < XTRA; i++) begin
          dv[i] <= 1'b0;
          dd[i] <= '0;
          de[i] <= 1'b0;
        end
      end else begin
        dv[0] <= s_valid;
        dd[0] <= s_data;
        de[0] <= s_exc;
        for (int i = 1; i < XTRA; i++) begin
          dv[i] <= dv[i-1];
          dd[i] <= dd[i-1];
          de[i] <= de[i-1];
        end
      end
    end
    assign valid_o = dv[XTRA-1];
    assign data_o  = dd[XTRA-1];
    assign exc_o   = de[XTRA-1];
  end else begin : g_nodly
    assign valid_o = s_valid;
    assign data_o  = s_data;
    assign exc_o   = s_exc;
  end

  AST_EXC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o) |-> (data_o == MAX_POS)); // R9
  AST_EXC_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i != '0) |=> !p_zero); // R9
endmodule

// File: tb/fx_range_scaler_tb.sv
`timescale 1ns/1ps
module fx_range_scaler_tb;
  localparam int LAT = 4;
  localparam int NV  = 22;

  // {func, data_in, expected_out, expected_exc}
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 12'h100, 12'h040, 1'b0},  // R3 1/1.0
    {2'd0, 12'h200, 12'h020, 1'b0},  // R3 1/2.0
    {2'd0, 12'hF00, 12'hFC0, 1'b0},  // R4 1/-1.0
    {2'd0, 12'h001, 12'h7FF, 1'b0},  // R8 overflow
    {2'd0, 12'h010, 12'h400, 1'b0},  // R8 largest in range
    {2'd0, 12'h008, 12'h7FF, 1'b0},  // R8 one past range
    {2'd0, 12'h000, 12'h7FF, 1'b1},  // R9 reciprocal of zero
    {2'd0, 12'h300, 12'h015, 1'b0},  // R7 1/3
    {2'd1, 12'h400, 12'h080, 1'b0},  // R5 sqrt 4
    {2'd1, 12'h200, 12'h05B, 1'b0},  // R6 sqrt 2, tie
    {2'd1, 12'h000, 12'h000, 1'b0},  // R9 sqrt of zero
    {2'd2, 12'h400, 12'h020, 1'b0},  // R5 rsqrt 4
    {2'd2, 12'h200, 12'h02D, 1'b0},  // R7 rsqrt 2
    {2'd2, 12'h000, 12'h7FF, 1'b1},  // R9 rsqrt of zero
    {2'd2, 12'h001, 12'h400, 1'b0},  // R5 rsqrt tiny
    {2'd0, 12'h7FF, 12'h008, 1'b0},  // R2 truncated mantissa
    {2'd1, 12'h001, 12'h004, 1'b0},  // R5 sqrt tiny
    {2'd0, 12'h800, 12'hFF8, 1'b0},  // R4 most negative
    {2'd2, 12'h800, 12'h017, 1'b0},  // R1 unsigned for roots
    {2'd0, 12'hFFF, 12'h801, 1'b0},  // R8 negative saturation
    {2'd3, 12'h400, 12'h080, 1'b0},  // R1 code 3 as sqrt
    {2'd0, 12'hD00, 12'hFEB, 1'b0}   // R6 -1/3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  func_i = '0;
  logic [11:0] data_i = '0;
  logic        valid_o, exc_o;
  logic [11:0] data_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fx_range_scaler #(.LATENCY(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .func_i(func_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o), .exc_o(exc_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(int n);
    logic [26:0] v = VEC[n];
    string tag = $sformatf("vector %0d", n);
    @(negedge clk);
    func_i  = v[26:25];
    data_i  = v[24:13];
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    for (int i = 1; i < LAT - 1; i++) @(negedge clk);
    chk({"R10 early valid ", tag}, 32'(valid_o), 32'd0);
    @(negedge clk);
    chk({"R10 valid ", tag}, 32'(valid_o), 32'd1);
    chk({"data ", tag}, 32'(data_o), 32'(v[12:1]));
    chk({"R9 exc ", tag}, 32'(exc_o), 32'(v[0]));
  endtask

  initial begin
    #1;
    chk("R10 reset valid", 32'(valid_o), 32'd0);
    chk("R10 reset data", 32'(data_o), 32'd0);
    chk("R10 reset exc", 32'(exc_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < NV; n++) run_vec(n);

    // R10 back-to-back stream: 1/1.0, sqrt 4, rsqrt 0
    @(negedge clk);
    func_i = 2'd0; data_i = 12'h100; valid_i = 1'b1;
    @(negedge clk);
    func_i = 2'd1; data_i = 12'h400;
    @(negedge clk);
    func_i = 2'd2; data_i = 12'h000;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R10 stream 0 valid", 32'(valid_o), 32'd1);
    chk("R10 stream 0 data", 32'(data_o), 32'h040);
    @(negedge clk);
    chk("R10 stream 1 valid", 32'(valid_o), 32'd1);
    chk("R10 stream 1 data", 32'(data_o), 32'h080);
    @(negedge clk);
    chk("R10 stream 2 data", 32'(data_o), 32'h7FF);
    chk("R9 stream 2 exc", 32'(exc_o), 32'd1);
    @(negedge clk);
    chk("R10 stream end valid", 32'(valid_o), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule